// File: doc/BRIEF.md
# Motion Sensor Power-Up and Detection Monitor

This block brings a motion sensor out of power-on reset and then turns its detect output into timestamped motion events. On a start request it removes the sensor's supply, waits a power-off interval, clears its edge count, restores the supply and lets it settle. It then watches the shared clock/detect line, which it only ever reads, until the sensor signals that its reset is over. The sensor does this by producing two transitions that leave the line low. If that does not happen in time, the block flags a timeout and returns to idle.

After a successful reset and a short guard interval, the block pulses a start strobe to an external serial configuration engine and waits for its done/ok answer. A good answer enables detection mode. In that mode every rising or falling transition of the line becomes one event, carrying a direction bit and the value of a free-running cycle counter, on a valid/ready output. An event that arrives while the previous one has not been taken is dropped and sets a sticky overflow flag. A bad configuration answer sends the block back to idle with detection off.

All intervals are given in clock cycles as parameters. Their defaults are sized for a 100 MHz clock: 35 ms power-off, 2 ms settle, 1300 ms reset wait and 10 us guard.

Top module: `sensor_watch`

## Requirements
- R1: Out of reset the supply enable is low, detection mode is off, no event is valid and the overflow flag is clear.
- R2: A start request accepted in idle or in detection mode drives the supply enable low at once and holds it low for OFF_CYC cycles before raising it.
- R3: Line transitions during the power-off wait do not count toward reset completion, because the count is cleared before power returns.
- R4: Once the supply is on, only transitions that leave the line low are counted, including those during the settle interval. Reset is complete when the count reaches RST_EDGES (2). Transitions that leave the line high never count.
- R5: If reset is not complete within TMO_CYC cycles after the settle interval ends, a single-cycle timeout pulse is given and the block returns to idle with the supply left on and detection off.
- R6: Reset completion is followed, after GAP_CYC cycles plus the synchronizer and edge-count latency, by a single-cycle configuration start pulse.
- R7: A configuration done with ok=1 enables detection mode. A done with ok=0 returns to idle with detection off.
- R8: In detection mode a transition to 1 gives an event with direction bit 1, and a transition to 0 gives an event with direction bit 0.
- R9: Each event carries the free-running counter value, so the timestamp difference between two events equals the cycle difference between the two line changes.
- R10: A pending event is held unchanged until accepted. A transition while an event is pending is dropped and sets the sticky overflow flag. A new start request clears the flag and any pending event.
- R11: Line transitions outside detection mode, in idle or during configuration, produce no event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Begin a power-cycle and bring-up sequence |
| lineIn | input | 1 | Shared clock/detect line from the sensor, asynchronous |
| cfgDone | input | 1 | Configuration engine finished (one-cycle strobe) |
| cfgOk | input | 1 | Configuration result, valid with cfgDone |
| supplyOn | output | 1 | Sensor supply enable |
| cfgStart | output | 1 | One-cycle strobe that starts configuration |
| rstTimeout | output | 1 | One-cycle pulse: reset did not complete in time |
| detecting | output | 1 | Detection mode active |
| evtValid | output | 1 | Event available |
| evtReady | input | 1 | Consumer takes the event |
| evtRising | output | 1 | Event direction, 1 = line went high |
| evtStamp | output | TS_W | Free-running cycle count when the edge was seen |
| evtOverflow | output | 1 | Sticky: an event was lost |

## Verification
The bench toggles the line twice during the power-off wait and then supplies no further transitions. A design that failed to clear or gate its count there would start configuration instead of timing out. In the bring-up run, one falling transition lands in the settle interval and one in the reset wait, with a rising transition between them. This catches a counter that ignores settle-time edges or counts transitions that leave the line high. It also catches a counter that completes reset one edge early or late. Timestamps are checked as differences against the bench's own cycle count, and a held event with a second edge exposes a design that overwrites the pending event or clears overflow on its own.

// File: rtl/sensor_watch_pkg.sv
package sensor_watch_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PWROFF,
    ST_SETTLE,
    ST_WAITRST,
    ST_GAP,
    ST_CONFIG,
    ST_DETECT
  } watchState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrEdges;    // clear reset-edge count
    logic countEdges;  // count edges that leave the line low
    logic detectOn;    // turn edges into events
    logic clrEvents;   // drop pending event and overflow
  } dpCtrl_t;

endpackage

// File: rtl/sensor_watch_dp.sv
module sensor_watch_dp
  import sensor_watch_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_EDGES   = 2,
  parameter int TS_W        = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            lineIn,
  input  dpCtrl_t         ctl,
  output logic            resetSeen,
  input  logic            evtReady,
  output logic            evtValid,
  output logic            evtRising,
  output logic [TS_W-1:0] evtStamp,
  output logic            evtOverflow
);

  localparam int CNT_W = $clog2(RST_EDGES + 1);

  logic [SYNC_STAGES-1:0] syncQ;
  logic                   lineS;
  logic                   lineD;
  logic                   edgeNow;
  logic [CNT_W-1:0]       edgeCnt;
  logic [TS_W-1:0]        tsCnt;

  // synchronizer chain
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end

  assign lineS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lineD <= 1'b0;
    else       lineD <= lineS;
  end

  assign edgeNow = lineS ^ lineD;

  // reset-completion edge count, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      edgeCnt <= '0;
    end else if (ctl.clrEdges) begin
      edgeCnt <= '0;
    end else if (ctl.countEdges && edgeNow && !lineS &&
                 edgeCnt != CNT_W'(RST_EDGES)) begin
      edgeCnt <= edgeCnt + 1'b1;
    end
  end

  assign resetSeen = (edgeCnt == CNT_W'(RST_EDGES));

  // free-running timestamp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tsCnt <= '0;
    else       tsCnt <= tsCnt + 1'b1;
  end

  // event register with overflow
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evtValid    <= 1'b0;
      evtRising   <= 1'b0;
      evtStamp    <= '0;
      evtOverflow <= 1'b0;
    end else if (ctl.clrEvents) begin
      evtValid    <= 1'b0;
      evtOverflow <= 1'b0;
    end else begin
      if (ctl.detectOn && edgeNow) begin
        if (evtValid && !evtReady) begin
          evtOverflow <= 1'b1;
        end else begin
          evtValid  <= 1'b1;
          evtRising <= lineS;
          evtStamp  <= tsCnt;
        end
      end else if (evtValid && evtReady) begin
        evtValid <= 1'b0;
      end
    end
  end

  // R4
  edge_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    edgeCnt <= CNT_W'(RST_EDGES));

  // R10
  evt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && !evtReady && !ctl.clrEvents) |=>
      (evtValid && $stable(evtStamp) && $stable(evtRising)));

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtOverflow && !ctl.clrEvents) |=> evtOverflow);

  // R11
  evt_only_detect_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(evtValid) |-> $past(ctl.detectOn));

endmodule

// File: rtl/sensor_watch_ctrl.sv
module sensor_watch_ctrl
  import sensor_watch_pkg::*;
#(
  parameter int OFF_CYC    = 3_500_000,
  parameter int SETTLE_CYC = 200_000,
  parameter int TMO_CYC    = 130_000_000,
  parameter int GAP_CYC    = 1_000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    startReq,
  input  logic    cfgDone,
  input  logic    cfgOk,
  input  logic    resetSeen,
  output dpCtrl_t ctl,
  output logic    supplyOn,
  output logic    cfgStart,
  output logic    rstTimeout,
  output logic    detecting
);

  localparam int MAX_AB = (OFF_CYC > SETTLE_CYC) ? OFF_CYC : SETTLE_CYC;
  localparam int MAX_CD = (TMO_CYC > GAP_CYC) ? TMO_CYC : GAP_CYC;
  localparam int MAXC   = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int TMR_W  = $clog2(MAXC + 1);

  watchState_e state;
  logic [TMR_W-1:0] tmr;
  logic tmrZero;
  logic startOk;

  assign tmrZero = (tmr == '0);
  assign startOk = startReq && (state == ST_IDLE || state == ST_DETECT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      tmr        <= '0;
      supplyOn   <= 1'b0;
      cfgStart   <= 1'b0;
      rstTimeout <= 1'b0;
    end else begin
      cfgStart   <= 1'b0;
      rstTimeout <= 1'b0;
      case (state)
        ST_IDLE, ST_DETECT: begin
          if (startOk) begin
            state    <= ST_PWROFF;
            supplyOn <= 1'b0;
            tmr      <= TMR_W'(OFF_CYC - 1);
          end
        end
        ST_PWROFF: begin
          if (tmrZero) begin
            state    <= ST_SETTLE;
            supplyOn <= 1'b1;
            tmr      <= TMR_W'(SETTLE_CYC - 1);
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_SETTLE: begin
          if (tmrZero) begin
            if (resetSeen) begin
              state <= ST_GAP;
              tmr   <= TMR_W'(GAP_CYC - 1);
            end else begin
              state <= ST_WAITRST;
              tmr   <= TMR_W'(TMO_CYC - 1);
            end
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_WAITRST: begin
          if (resetSeen) begin
            state <= ST_GAP;
            tmr   <= TMR_W'(GAP_CYC - 1);
          end else if (tmrZero) begin
            state      <= ST_IDLE;
            rstTimeout <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_GAP: begin
          if (tmrZero) begin
            state    <= ST_CONFIG;
            cfgStart <= 1'b1;
          end else begin
            tmr <= tmr - 1'b1;
          end
        end
        ST_CONFIG: begin
          if (cfgDone) state <= cfgOk ? ST_DETECT : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.clrEdges   = (state == ST_PWROFF);
    ctl.clrEvents  = (state == ST_PWROFF);
    ctl.countEdges = (state == ST_SETTLE) || (state == ST_WAITRST);
    ctl.detectOn   = (state == ST_DETECT);
  end

  assign detecting = (state == ST_DETECT);

  // R2
  supply_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    startOk |=> !supplyOn);

  // R5
  timeout_supply_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstTimeout |-> (supplyOn && !detecting));

  // R6
  cfg_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgStart |=> !cfgStart);

  // R7
  cfg_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONFIG && cfgDone && !cfgOk) |=> !detecting);

endmodule

// File: rtl/sensor_watch.sv
module sensor_watch
  import sensor_watch_pkg::*;
#(
  parameter int OFF_CYC     = 3_500_000,
  parameter int SETTLE_CYC  = 200_000,
  parameter int TMO_CYC     = 130_000_000,
  parameter int GAP_CYC     = 1_000,
  parameter int RST_EDGES   = 2,
  parameter int SYNC_STAGES = 2,
  parameter int TS_W        = 32
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startReq,
  input  logic            lineIn,
  input  logic            cfgDone,
  input  logic            cfgOk,
  output logic            supplyOn,
  output logic            cfgStart,
  output logic            rstTimeout,
  output logic            detecting,
  output logic            evtValid,
  input  logic            evtReady,
  output logic            evtRising,
  output logic [TS_W-1:0] evtStamp,
  output logic            evtOverflow
);

  dpCtrl_t ctl;
  logic    resetSeen;

  sensor_watch_ctrl #(
    .OFF_CYC   (OFF_CYC),
    .SETTLE_CYC(SETTLE_CYC),
    .TMO_CYC   (TMO_CYC),
    .GAP_CYC   (GAP_CYC)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .startReq  (startReq),
    .cfgDone   (cfgDone),
    .cfgOk     (cfgOk),
    .resetSeen (resetSeen),
    .ctl       (ctl),
    .supplyOn  (supplyOn),
    .cfgStart  (cfgStart),
    .rstTimeout(rstTimeout),
    .detecting (detecting)
  );

  sensor_watch_dp #(
    .SYNC_STAGES(SYNC_STAGES),
    .RST_EDGES  (RST_EDGES),
    .TS_W       (TS_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .lineIn     (lineIn),
    .ctl        (ctl),
    .resetSeen  (resetSeen),
    .evtReady   (evtReady),
    .evtValid   (evtValid),
    .evtRising  (evtRising),
    .evtStamp   (evtStamp),
    .evtOverflow(evtOverflow)
  );

endmodule

// File: tb/sensor_watch_test.sv
`timescale 1ns/1ps
module sensor_watch_test;

  localparam int OFF = 20;
  localparam int SET = 10;
  localparam int TMO = 60;
  localparam int GAP = 5;
  localparam int NV  = 4;
  // line level and idle cycles after each event
  localparam logic       VLEV [NV] = '{1'b1, 1'b0, 1'b1, 1'b0};
  localparam int         VGAP [NV] = '{7, 12, 5, 9};

  logic clk = 0;
  logic rstN = 0;
  logic startReq = 0, lineIn = 0, cfgDone = 0, cfgOk = 0, evtReady = 0;
  logic supplyOn, cfgStart, rstTimeout, detecting, evtValid, evtRising, evtOverflow;
  logic [31:0] evtStamp;

  int total = 0, bad = 0;
  int cyc = 0;
  int n, t0, tPrev, sPrev, seenTo, seenCfg;
  logic [31:0] held;

  sensor_watch #(.OFF_CYC(OFF), .SETTLE_CYC(SET), .TMO_CYC(TMO), .GAP_CYC(GAP)) uut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .lineIn(lineIn),
    .cfgDone(cfgDone), .cfgOk(cfgOk), .supplyOn(supplyOn), .cfgStart(cfgStart),
    .rstTimeout(rstTimeout), .detecting(detecting), .evtValid(evtValid),
    .evtReady(evtReady), .evtRising(evtRising), .evtStamp(evtStamp),
    .evtOverflow(evtOverflow));

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  task automatic pulseStart();
    startReq = 1; @(negedge clk); startReq = 0;
  endtask

  task automatic waitSupply();
    n = 0;
    while (!supplyOn && n < 200) begin @(negedge clk); n++; end
  endtask

  initial begin
    #2_000_000;
    chk(0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cycles(3);
    rstN = 1;
    cycles(2);
    // R1 reset state
    chk(!supplyOn && !detecting, "R1 supply/detect", {supplyOn, detecting}, 0);
    chk(!evtValid && !evtOverflow, "R1 event/overflow", {evtValid, evtOverflow}, 0);
    // R11 idle edges
    lineIn = 1; cycles(5); lineIn = 0; cycles(5);
    chk(!evtValid, "R11 idle edge", evtValid, 0);

    // timeout run with edges inside the power-off wait
    pulseStart();
    chk(!supplyOn, "R2 supply low", supplyOn, 0);
    n = 1;
    seenCfg = 0;
    while (!supplyOn && n < 200) begin
      if (n == 2 || n == 8) lineIn = 1;
      if (n == 5 || n == 11) lineIn = 0;
      @(negedge clk); n++;
    end
    // R2 power-off length
    chk(n >= OFF - 1 && n <= OFF + 2, "R2 off length", n, OFF);
    seenTo = 0;
    for (int i = 0; i < SET + TMO + 20; i++) begin
      if (rstTimeout) seenTo++;
      if (cfgStart) seenCfg++;
      @(negedge clk);
    end
    chk(seenCfg == 0, "R3 edges in power-off ignored", seenCfg, 0);
    chk(seenTo == 1, "R5 timeout pulse", seenTo, 1);
    chk(supplyOn && !detecting, "R5 idle after timeout", {supplyOn, detecting}, 2);

    // bring-up: one fall in settle, one rise and fall in reset wait
    pulseStart();
    waitSupply();
    cycles(1); lineIn = 1; cycles(3); lineIn = 0;
    seenCfg = 0;
    for (int i = 0; i < SET + 6; i++) begin
      if (cfgStart) seenCfg++;
      @(negedge clk);
    end
    lineIn = 1;
    for (int i = 0; i < 6; i++) begin
      if (cfgStart) seenCfg++;
      @(negedge clk);
    end
    chk(seenCfg == 0, "R4 one fall and rise not enough", seenCfg, 0);
    lineIn = 0;
    n = 0;
    while (!cfgStart && n < 100) begin @(negedge clk); n++; end
    chk(n >= GAP + 2 && n <= GAP + 6, "R4/R6 start after second fall", n, GAP + 4);
    @(negedge clk);
    chk(!cfgStart, "R6 single pulse", cfgStart, 0);
    // R11 edges during configuration
    lineIn = 1; cycles(5); lineIn = 0; cycles(5);
    chk(!evtValid && !detecting, "R11 config edge", evtValid, 0);
    cfgOk = 1; cfgDone = 1; @(negedge clk); cfgDone = 0; cfgOk = 0;
    chk(detecting, "R7 ok enables detection", detecting, 1);

    // table of line changes, each checked for direction and timestamp
    for (int v = 0; v < NV; v++) begin
      lineIn = VLEV[v];
      t0 = cyc;
      cycles(5);
      chk(evtValid, "R8 event valid", evtValid, 1);
      chk(evtRising == VLEV[v], "R8 direction", evtRising, VLEV[v]);
      if (v > 0)
        chk(int'(evtStamp) - sPrev == t0 - tPrev, "R9 stamp delta",
            int'(evtStamp) - sPrev, t0 - tPrev);
      sPrev = int'(evtStamp);
      tPrev = t0;
      evtReady = 1; @(negedge clk); evtReady = 0;
      chk(!evtValid, "R10 accepted clears", evtValid, 0);
      cycles(VGAP[v]);
    end

    // overflow while pending
    lineIn = 1; cycles(5);
    held = evtStamp;
    lineIn = 0; cycles(5);
    chk(evtOverflow, "R10 overflow set", evtOverflow, 1);
    chk(evtValid && evtRising && evtStamp == held, "R10 first event kept",
        evtStamp, held);
    evtReady = 1; @(negedge clk); evtReady = 0;
    cycles(3);
    chk(evtOverflow && !evtValid, "R10 overflow sticky", evtOverflow, 1);

    // restart from detection, then configuration failure
    pulseStart();
    cycles(2);
    chk(!supplyOn && !detecting, "R2 restart from detect", supplyOn, 0);
    chk(!evtOverflow, "R10 restart clears overflow", evtOverflow, 1'b0);
    waitSupply();
    lineIn = 1; cycles(3); lineIn = 0; cycles(3);
    lineIn = 1; cycles(3); lineIn = 0;
    n = 0;
    while (!cfgStart && n < 200) begin @(negedge clk); n++; end
    chk(cfgStart, "R6 start after settle edges", cfgStart, 1);
    cfgOk = 0; cfgDone = 1; @(negedge clk); cfgDone = 0;
    chk(!detecting, "R7 fail returns idle", detecting, 0);
    lineIn = 1; cycles(6);
    chk(!evtValid, "R11 no event after fail", evtValid, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule